// File: doc/BRIEF.md
# Bit-Six Expiry Watchdog Timer

This block supervises software on a small microcontroller. One 8-bit control register holds a sticky arm flag in bit 7 and a 7-bit down-counter in bits 6:0. A fixed prescaler divides the CPU clock, and each prescaler tick lowers the counter by one. When the watchdog is armed and counter bit 6 drops from one to zero (the step from 40h to 3Fh), the block drives a fixed-length active-low reset pulse.

To keep the system alive, software rewrites the register often enough, using a value from C0h to FFh. Each write reloads the counter and restarts the prescaler. Bits 5:0 of that value set the timeout in 64 steps. With a written value of C0h+n, the reset follows (n+1) prescaler periods after the write, unless software refreshes first.

The register port is a plain single-cycle write strobe with a combinational read-back. It has no valid/ready handshake, because a register write cannot be back-pressured and is always accepted in the cycle it is presented. The reset output is a plain level.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `rd_data` reads 7Fh (disarmed, counter 7Fh) and `wd_reset_n` is high.
- R2: `rd_data` always returns the arm flag in bit 7 and the live counter in bits 6:0.
- R3: Without writes, the counter drops by one every `PRESCALE` clock cycles and wraps from 00h to 7Fh.
- R4: A write loads bits 6:0 into the counter and restarts the prescaler, so the first decrement lands `PRESCALE` cycles after the write edge.
- R5: A write with bit 7 = 1 arms the watchdog. A write with bit 7 = 0 never disarms it; only `rst_n` clears the arm flag.
- R6: When armed, the tick that takes the counter from 40h to 3Fh starts a reset pulse in the next cycle. A write of C0h+n therefore leads to a pulse (n+1)·`PRESCALE` cycles after the write edge.
- R7: While disarmed, no reset pulse is produced, even when the counter passes from 40h to 3Fh or is written with bit 6 = 0.
- R8: A write that leaves the watchdog armed with bit 6 = 0 starts the reset pulse in the cycle after the write.
- R9: `wd_reset_n` stays low for exactly `PULSE_CYCLES` cycles. A new trigger during a pulse restarts the full length from that trigger.
- R10: Rewriting the register before bit 6 clears prevents any reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU machine-cycle clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write value: bit 7 arm, bits 6:0 counter |
| rd_data | output | 8 | Read-back: arm flag and live counter |
| wd_reset_n | output | 1 | Watchdog reset pulse, active low |

## Verification
The counter is run disarmed across the 40h boundary and the 00h wrap. This separates plain counting from expiry, and shows that the disarmed state really suppresses the pulse. Armed runs use different timeout values, which shows that the pulse time follows the loaded value and the restarted prescaler rather than a free-running phase. Periodic refreshes show that reloads hold off expiry. Immediate bit-6-clear writes, a retrigger inside a running pulse, and disarming writes after arming isolate the arm-flag and pulse-length rules. A scoreboard compares every pulse's start cycle and length against the predicted values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 7;
  localparam int unsigned REG_W  = CNT_W + 1;
  localparam int unsigned TOP_BIT = CNT_W - 1;
  localparam logic [CNT_W-1:0] EXPIRE_VAL = CNT_W'(1) << TOP_BIT;
  localparam logic [CNT_W-1:0] RESET_CNT  = '1;

  typedef struct packed {
    logic             arm;
    logic [CNT_W-1:0] cnt;
  } wdog_reg_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 49152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (restart || tick) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assert_no_tick_after_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
  assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  wdog_reg_t        wr_val,
  input  logic             tick,
  output wdog_reg_t        state,
  output logic             fire
);
  wdog_reg_t nxt;
  logic      crosses;

  always_comb begin
    nxt = state;
    nxt.arm = state.arm | (wr_en & wr_val.arm);
    if (wr_en)     nxt.cnt = wr_val.cnt;
    else if (tick) nxt.cnt = state.cnt - 1'b1;
  end

  assign crosses = wr_en ? !wr_val.cnt[TOP_BIT]
                         : (tick && state.cnt == EXPIRE_VAL);
  assign fire = nxt.arm & crosses;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= '{arm: 1'b0, cnt: RESET_CNT};
    else        state <= nxt;
  end

  assert_decrement_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> state.cnt == $past(state.cnt) - 1'b1);
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(state));
  assert_arm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state.arm |=> state.arm);
  assert_fire_only_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> state.arm);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int unsigned LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LOAD = LW'(LEN);

  logic [LW-1:0] remain;

  assign pulse_n = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             remain <= '0;
    else if (fire)          remain <= LOAD;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assert_fire_starts_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pulse_n);
  assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_n) |-> $past(fire));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE     = 49152,
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             wd_reset_n
);
  logic      tick;
  logic      fire;
  wdog_reg_t state;

  wdog_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .tick(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wdog_reg_t'(wr_data)),
    .tick(tick), .state(state), .fire(fire)
  );

  wdog_pulse #(.LEN(PULSE_CYCLES)) u_pls (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse_n(wd_reset_n)
  );

  assign rd_data = state;

  assert_write_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]));
  assert_write_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[REG_W-1]) |=> rd_data[REG_W-1]);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == 8'h7F && wd_reset_n));
endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  localparam int P = 16;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wd_reset_n;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int wr_at = 0;
  int exp_start[$];
  int exp_len[$];
  int cur_len = 0;
  int want_len = 0;
  logic prev_n = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.PRESCALE(P), .PULSE_CYCLES(L)) u_wdog_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wd_reset_n(wd_reset_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // assumes caller sits at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_at = cyc;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_pulse(input int start, input int len);
    exp_start.push_back(start);
    exp_len.push_back(len);
  endtask

  // monitor: pops predicted pulses as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (!wd_reset_n) begin
        if (prev_n) begin
          if (exp_start.size() == 0) begin
            chk("R7/R10 unexpected pulse", cyc, -1);
            want_len = L;
          end else begin
            chk("R6/R8 pulse start", cyc, exp_start.pop_front());
            want_len = exp_len.pop_front();
          end
          cur_len = 1;
        end else cur_len++;
      end else if (!prev_n) begin
        chk("R9 pulse length", cur_len, want_len);
      end
    end
    prev_n = wd_reset_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset read", rd_data, 8'h7F);
    chk("R1 reset out", wd_reset_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data, 8'h7F);

    // disarmed counting, reload and wrap
    wr(8'h01);
    chk("R2 R4 reload", rd_data, 8'h01);
    wait_to(wr_at + P - 1);
    chk("R4 no early decrement", rd_data, 8'h01);
    wait_to(wr_at + P);
    chk("R3 decrement", rd_data, 8'h00);
    wait_to(wr_at + 2*P);
    chk("R3 wrap", rd_data, 8'h7F);

    // disarmed pass through 40h: no pulse
    wr(8'h42);
    wait_to(wr_at + 3*P);
    chk("R7 disarmed crossing", rd_data, 8'h3F);
    chk("R7 out high", wd_reset_n, 1);
    wr(8'h45);
    chk("R5 bit7 zero stays disarmed", rd_data, 8'h45);
    wr(8'h10);
    wait_to(wr_at + L + 2);
    chk("R7 disarmed bit6 clear", rd_data[7], 0);

    // armed expiry with timeout C3h
    wr(8'hC3);
    expect_pulse(wr_at + 4*P, L);
    chk("R5 arm", rd_data, 8'hC3);
    wait_to(wr_at + 4*P + L + 2);
    chk("R6 counter after expiry", rd_data, 8'hBF);

    // periodic refresh holds off expiry
    wr(8'hC2);
    for (int i = 0; i < 5; i++) begin
      wait_to(wr_at + 2*P - 1);
      wr(8'hC2);
    end
    chk("R10 refreshed value", rd_data, 8'hC2);
    expect_pulse(wr_at + 3*P, L);
    wait_to(wr_at + 3*P + L + 2);

    // write with bit7 = 0 does not disarm
    wr(8'h44);
    chk("R5 sticky arm", rd_data, 8'hC4);
    expect_pulse(wr_at + 5*P, L);
    wait_to(wr_at + 5*P + L + 2);

    // immediate trigger by bit6 = 0
    wr(8'hA0);
    expect_pulse(wr_at, L);
    wait_to(wr_at + L + 2);

    // retrigger inside a pulse
    wr(8'h90);
    expect_pulse(wr_at, L + 3);
    wait_to(wr_at + 2);
    wr(8'h90);
    wait_to(wr_at + L + 2);

    // system reset disarms
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 R5 reset disarms", rd_data, 8'h7F);
    @(negedge clk);
    wr(8'h05);
    wait_to(wr_at + L + 2);
    chk("R7 bit6 clear after reset", wd_reset_n, 1);

    chk("scoreboard drained", exp_start.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule